// File: doc/BRIEF.md
# Next-PC and Link Address Unit

This block owns the program counter of a 32-bit single-cycle processor core and decides, every clock, which address is fetched next. It produces the fall-through address PC+4 every cycle. It also forms three redirect targets:

- a PC-relative branch target;
- an absolute jump target, assembled from the 26-bit field of the instruction word;
- a register target taken directly from an operand.

A two-bit source select from the decoder chooses among these four addresses. For the branch source, a branch-taken flag from the comparator also has a say. The chosen address is loaded into the PC register on the next rising clock edge.

The same PC+4 value is always presented on a link output. The register-file write-data selector takes this value as the return address for call instructions, writing it to register 31 when a jump-and-link executes. The unit does not decide whether the link is written; the decoder does. The instruction word, branch-taken flag, register operand and select come from neighbouring logic (decoder, comparator, register file) that is outside this block.

The selection is organised as a small state decoder over an enumerated source type: SRC_SEQ, SRC_BRANCH, SRC_JUMP and SRC_REG. The PC register moves from whatever address it holds to the address named by the current source on every clock edge. The one exception is reset, which forces it to zero.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the PC register loads 0x00000000 (synchronous, active-high reset).
- R2: With `pc_src` = 2'b00 (SRC_SEQ), `next_pc` equals `pc` + 4, modulo 2^32.
- R3: With `pc_src` = 2'b01 (SRC_BRANCH) and `branch_taken` high, `next_pc` equals `pc` + 4 plus four times the signed 16-bit value in `instr[15:0]`, modulo 2^32.
- R4: With `pc_src` = 2'b01 and `branch_taken` low, `next_pc` equals `pc` + 4, whatever the offset field holds.
- R5: With `pc_src` = 2'b10 (SRC_JUMP), `next_pc` equals {(`pc`+4)[31:28], `instr[25:0]`, 2'b00}.
- R6: With `pc_src` = 2'b11 (SRC_REG), `next_pc` equals `rs_value` exactly. The unit applies no alignment to it, and `branch_taken` has no effect.
- R7: `link` equals `pc` + 4 at all times, independent of `pc_src`, `branch_taken`, `instr` and `rs_value`.
- R8: Outside reset, the value of `pc` after a rising edge equals the `next_pc` presented before that edge.
- R9: Address arithmetic wraps: from `pc` = 0xFFFFFFFC, both the sequential address and `link` are 0x00000000.
- R10: The upper four bits of a jump target come from `pc`+4, not from `pc`. For `pc` = 0x0FFFFFFC they are 4'h1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the PC register |
| instr | input | 32 | Current instruction word (offset field in [15:0], target field in [25:0]) |
| pc_src | input | 2 | Next-PC source: 00 sequential, 01 branch, 10 jump, 11 register |
| branch_taken | input | 1 | Branch condition result, used only with source 01 |
| rs_value | input | 32 | Register operand for register jumps |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | Address to be loaded at the next clock edge |
| link | output | 32 | Return address PC+4 for the write-data selector |

## Verification
The bench builds the unit with its default parameters: a 32-bit address, a 16-bit branch offset and a 26-bit jump field. This keeps the bit boundaries where the sign extension and the PC+4 upper-bit merge happen. Because the register source can place any address into the PC, the bench sweeps a set of start addresses that includes the wrap point 0xFFFFFFFC and the 256 MB region edge 0x0FFFFFFC. At each start address it applies every source, both taken-flag values and instruction words with positive, negative, extreme and all-ones fields. This puts sign extension at both ends, region crossing and modular wrap within reach of the arithmetic expectations.

// File: rtl/npc_pkg.sv
package npc_pkg;

    // Next-PC source encoding driven by the decoder.
    typedef enum logic [1:0] {
        SRC_SEQ    = 2'b00,
        SRC_BRANCH = 2'b01,
        SRC_JUMP   = 2'b10,
        SRC_REG    = 2'b11
    } pc_src_e;

    // Byte distance between consecutive instruction words.
    localparam int unsigned INSN_BYTES = 4;
    // Low address bits implied by word alignment.
    localparam int unsigned ALIGN_BITS = 2;

endpackage

// File: rtl/npc_incr.sv
module npc_incr #(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0] pc_i,
    output logic [XLEN-1:0] seq_o
);
    import npc_pkg::*;

    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    // Wraps modulo 2^XLEN by width.
    assign seq_o = pc_i + STEP;

endmodule

// File: rtl/npc_branch_tgt.sv
module npc_branch_tgt #(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned OFF_W = 16
) (
    input  logic [XLEN-1:0]  seq_i,
    input  logic [OFF_W-1:0] off_i,
    output logic [XLEN-1:0]  tgt_o
);
    import npc_pkg::*;

    localparam int unsigned EXT_W = XLEN - OFF_W - ALIGN_BITS;

    logic [XLEN-1:0] byte_off;

    // Sign-extend the instruction count and scale it to bytes.
    assign byte_off = {{EXT_W{off_i[OFF_W-1]}}, off_i, {ALIGN_BITS{1'b0}}};
    assign tgt_o    = seq_i + byte_off;

endmodule

// File: rtl/npc_jump_tgt.sv
module npc_jump_tgt #(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned TGT_W = 26
) (
    input  logic [XLEN-1:0]  seq_i,
    input  logic [TGT_W-1:0] field_i,
    output logic [XLEN-1:0]  tgt_o
);
    import npc_pkg::*;

    localparam int unsigned HI_W = XLEN - TGT_W - ALIGN_BITS;

    // Region bits come from the incremented address.
    assign tgt_o = {seq_i[XLEN-1 -: HI_W], field_i, {ALIGN_BITS{1'b0}}};

endmodule

// File: rtl/npc_select.sv
module npc_select #(
    parameter int unsigned XLEN = 32
) (
    input  npc_pkg::pc_src_e src_i,
    input  logic             taken_i,
    input  logic [XLEN-1:0]  seq_i,
    input  logic [XLEN-1:0]  br_i,
    input  logic [XLEN-1:0]  jmp_i,
    input  logic [XLEN-1:0]  reg_i,
    output logic [XLEN-1:0]  next_o
);
    import npc_pkg::*;

    always_comb begin
        unique case (src_i)
            SRC_SEQ:    next_o = seq_i;
            SRC_BRANCH: next_o = taken_i ? br_i : seq_i;
            SRC_JUMP:   next_o = jmp_i;
            SRC_REG:    next_o = reg_i;
            default:    next_o = seq_i;
        endcase
    end

endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
    parameter int unsigned       XLEN     = 32,
    parameter int unsigned       OFF_W    = 16,
    parameter int unsigned       TGT_W    = 26,
    parameter logic [XLEN-1:0]   RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [XLEN-1:0] instr,
    input  logic [1:0]      pc_src,
    input  logic            branch_taken,
    input  logic [XLEN-1:0] rs_value,
    output logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] next_pc,
    output logic [XLEN-1:0] link
);
    import npc_pkg::*;

    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] seq_addr;
    logic [XLEN-1:0] br_addr;
    logic [XLEN-1:0] jmp_addr;
    logic [XLEN-1:0] sel_addr;
    pc_src_e         src;
    logic            unused_opcode;

    assign src           = pc_src_e'(pc_src);
    assign unused_opcode = ^instr[XLEN-1:TGT_W];

    npc_incr #(.XLEN(XLEN)) u_incr (
        .pc_i  (pc_q),
        .seq_o (seq_addr)
    );

    npc_branch_tgt #(.XLEN(XLEN), .OFF_W(OFF_W)) u_br (
        .seq_i (seq_addr),
        .off_i (instr[OFF_W-1:0]),
        .tgt_o (br_addr)
    );

    npc_jump_tgt #(.XLEN(XLEN), .TGT_W(TGT_W)) u_jmp (
        .seq_i   (seq_addr),
        .field_i (instr[TGT_W-1:0]),
        .tgt_o   (jmp_addr)
    );

    npc_select #(.XLEN(XLEN)) u_sel (
        .src_i   (src),
        .taken_i (branch_taken),
        .seq_i   (seq_addr),
        .br_i    (br_addr),
        .jmp_i   (jmp_addr),
        .reg_i   (rs_value),
        .next_o  (sel_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) pc_q <= RESET_PC;
        else     pc_q <= sel_addr;
    end

    assign pc      = pc_q;
    assign next_pc = sel_addr;
    assign link    = seq_addr;

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
    parameter int unsigned XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic [1:0]      pc_src,
    input logic            branch_taken,
    input logic [XLEN-1:0] rs_value,
    input logic [XLEN-1:0] pc,
    input logic [XLEN-1:0] next_pc,
    input logic [XLEN-1:0] link
);
    // R1: reset loads zero
    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> (pc == '0));

    // R2: sequential source equals the incremented address
    p_seq_r2: assert property (@(posedge clk) disable iff (rst)
        (pc_src == 2'b00) |-> (next_pc == pc + XLEN'(4)));

    // R4: untaken branch falls through
    p_untaken_r4: assert property (@(posedge clk) disable iff (rst)
        (pc_src == 2'b01 && !branch_taken) |-> (next_pc == link));

    // R5: jump target is word aligned and keeps the link region bits
    p_jump_region_r5: assert property (@(posedge clk) disable iff (rst)
        (pc_src == 2'b10) |-> (next_pc[1:0] == 2'b00
                               && next_pc[XLEN-1 -: 4] == link[XLEN-1 -: 4]));

    // R6: register source passes the operand through
    p_reg_r6: assert property (@(posedge clk) disable iff (rst)
        (pc_src == 2'b11) |-> (next_pc == rs_value));

    // R7: link is always PC+4
    p_link_r7: assert property (@(posedge clk) disable iff (rst)
        link == pc + XLEN'(4));

    // R8: the register follows the selected address
    p_follow_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (pc == $past(next_pc)));

endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .pc_src       (pc_src),
    .branch_taken (branch_taken),
    .rs_value     (rs_value),
    .pc           (pc),
    .next_pc      (next_pc),
    .link         (link)
);

// File: tb/sim_npc_unit.sv
module sim_npc_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] instr;
    logic [1:0]  pc_src;
    logic        branch_taken;
    logic [31:0] rs_value;
    logic [31:0] pc;
    logic [31:0] next_pc;
    logic [31:0] link;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    npc_unit u0 (
        .clk          (clk),
        .rst          (rst),
        .instr        (instr),
        .pc_src       (pc_src),
        .branch_taken (branch_taken),
        .rs_value     (rs_value),
        .pc           (pc),
        .next_pc      (next_pc),
        .link         (link)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            n_run  = n_run + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run = n_run + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] instr_pat(input int k);
        case (k)
            0:       return 32'h0C00_0000;
            1:       return 32'h0BFF_FFFF;
            2:       return 32'h1000_7FFF;
            3:       return 32'h1111_8000;
            4:       return 32'h0C12_3456;
            default: return 32'hA5A5_A5A5;
        endcase
    endfunction

    function automatic logic [31:0] pc_pat(input int i);
        case (i)
            0:       return 32'h0000_0000;
            1:       return 32'h0000_0004;
            2:       return 32'hFFFF_FFFC;
            3:       return 32'h0FFF_FFFC;
            4:       return 32'h7FFF_FFFC;
            5:       return 32'h8000_0000;
            default: return ((i * 32'h1111_1114) ^ (32'(i) << 28)) & 32'hFFFF_FFFC;
        endcase
    endfunction

    function automatic logic [31:0] expect_next(input logic [31:0] p, input int sel,
                                                input logic tk, input logic [31:0] ins,
                                                input logic [31:0] rs);
        logic [31:0] p4;
        int          off;
        p4 = p + 32'd4;
        off = int'(ins[15:0]);
        if (ins[15]) off = off - 65536;
        case (sel)
            0:       return p4;
            1:       return tk ? p4 + 32'(off * 4) : p4;
            2:       return (p4 & 32'hF000_0000) | ((ins & 32'h03FF_FFFF) * 32'd4);
            default: return rs;
        endcase
    endfunction

    task automatic load_pc(input logic [31:0] v);
        @(negedge clk);
        pc_src   = 2'b11;
        rs_value = v;
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; instr = '0; pc_src = 2'b00; branch_taken = 1'b0; rs_value = '0;
        repeat (2) @(negedge clk);
        check("R1 reset pc", pc, 32'h0);
        check("R7 link after reset", link, 32'h4);
        rst = 1'b0;

        for (int i = 0; i < 18; i++) begin
            for (int sel = 0; sel < 4; sel++) begin
                for (int tk = 0; tk < 2; tk++) begin
                    for (int k = 0; k < 6; k++) begin
                        logic [31:0] p, ins, rs, e;
                        string tag;
                        p   = pc_pat(i);
                        ins = instr_pat(k);
                        rs  = {ins[15:0], ins[31:16]} ^ p ^ 32'h1;
                        load_pc(p);
                        check("R8 loaded pc", pc, p);
                        pc_src = 2'(sel); branch_taken = 1'(tk);
                        instr = ins; rs_value = rs;
                        #1;
                        e = expect_next(p, sel, 1'(tk), ins, rs);
                        case (sel)
                            0:       tag = "R2 sequential";
                            1:       tag = (tk != 0) ? "R3 branch taken" : "R4 branch untaken";
                            2:       tag = "R5 jump";
                            default: tag = "R6 register";
                        endcase
                        check(tag, next_pc, e);
                        check("R7 link", link, p + 32'd4);
                        @(negedge clk);
                        check("R8 pc follows next", pc, e);
                    end
                end
            end
        end

        // R9 wrap
        load_pc(32'hFFFF_FFFC);
        pc_src = 2'b00; #1;
        check("R9 wrap next", next_pc, 32'h0);
        check("R9 wrap link", link, 32'h0);
        @(negedge clk);
        check("R9 wrap pc", pc, 32'h0);

        // R10 region taken from pc+4
        load_pc(32'h0FFF_FFFC);
        pc_src = 2'b10; instr = 32'h0800_0010; #1;
        check("R10 jump region", next_pc, 32'h1000_0040);

        // R3 negative branch reaching back across zero
        load_pc(32'h0000_0008);
        pc_src = 2'b01; branch_taken = 1'b1; instr = 32'h1000_FFFC; #1;
        check("R3 negative wrap", next_pc, 32'hFFFF_FFFC);

        // R1 mid-run reset
        @(negedge clk);
        rst = 1'b1; pc_src = 2'b11; rs_value = 32'h1234_5678;
        @(negedge clk);
        check("R1 reset mid-run", pc, 32'h0);
        rst = 1'b0;

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule